// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block divides a bit stream by a generator polynomial over GF(2), one bit per clock. A single shift register with feedback does both jobs. In generate mode it produces the systematic check bits for a message. In check mode it tests a received codeword. The polynomial and its degree are parameters. The default is the 16-bit polynomial x^16+x^12+x^5+1. The 5-bit and 32-bit polynomials in common use need only a change of parameters.

To use it, the caller pulses `start` and selects the mode at the same time. It then presents bits most significant first on `bit_in`, qualified by `bit_valid`, and marks the final bit with `last`.

- In generate mode, the caller supplies only the message. The block appends the degree-many zero bits by itself. When it finishes, `crc` holds the remainder of m(x)·x^W divided by g(x). Sending the message followed by these bits gives the codeword.
- In check mode, the caller shifts in the whole codeword. `error` reports a nonzero final register, and `crc` shows that remainder.

Top module: `serial_crc_unit`

## Requirements
- R1: After reset, `crc` is all zeros and `done` and `error` are low.
- R2: A cycle with `start` high clears the register. With `bit_valid` low in that cycle, `crc` reads zero in the next cycle.
- R3: In generate mode (`mode`=0), `crc` at `done` equals the remainder of m(x)·x^W modulo g(x). Message bits enter most significant first. g(x) is x^W plus the terms set in `POLY`, where bit i of `POLY` is the coefficient of x^i.
- R4: `done` first rises W clock edges after the edge that accepts the last message bit in generate mode. In check mode (`mode`=1) it rises at the very edge that accepts the last bit.
- R5: `done` lasts one cycle, and `crc` holds its value afterwards until the next `start`.
- R6: In check mode, a codeword made of a message followed by its W check bits gives `error`=0 and `crc`=0 at `done`.
- R7: In check mode, a codeword with one flipped bit gives `error`=1. So does a codeword with a burst of flips spanning at most W bits.
- R8: Idle cycles with `bit_valid` low inside a message do not change the result. Valid bits presented while no message is open are also ignored.
- R9: Bits presented while the block appends its own zeros in generate mode do not change the result or the timing.
- R10: `error` is never high while `done` is low.
- R11: The mode is taken in the `start` cycle. Changing `mode` later in the message has no effect.
- R12: With W=2 and g(x)=x^2+1, the message 0110 yields check bits 11. The codeword 011011 then checks clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a message and clears the register |
| mode | input | 1 | 0 generate, 1 check; sampled with `start` |
| bit_in | input | 1 | Serial data bit, most significant first |
| bit_valid | input | 1 | Qualifies `bit_in` |
| last | input | 1 | Marks the final bit of the message or codeword |
| crc | output | W | Register contents: check bits or syndrome |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Nonzero syndrome at the end of a check |

## Verification
The embedded assertions check the following on every cycle:
- `error` is high only with `done`.
- A start with no bit leaves a zero register.
- The register holds still on cycles with no shift.
- The internal zero flush always ends in a `done`.
- `done` never repeats without a new start.

Only the bench scenarios can show the following:
- The arithmetic of the remainder, against an independent long division over several message lengths and a known 72-bit value.
- The exact cycle at which `done` rises in each mode.
- Detection of flipped and burst-corrupted codewords.
- That stray bits, idle gaps and late mode changes leave the result alone.
- The two-bit worked case.

// File: rtl/serial_crc_unit.sv
module serial_crc_unit #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode,
  input  logic         bit_in,
  input  logic         bit_valid,
  input  logic         last,
  output logic [W-1:0] crc,
  output logic         done,
  output logic         error
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [CW-1:0] pad_q;
  logic          open_q, chk_q, done_q;

  logic          take, padding, chk_now, din;
  logic [W-1:0]  base, stepped;

  assign padding = (pad_q != '0) && !start;
  assign take    = bit_valid && (start || (open_q && pad_q == '0));
  assign chk_now = start ? mode : chk_q;
  assign base    = start ? '0 : rem_q;
  assign din     = take ? bit_in : 1'b0;
  assign stepped = ((base << 1) | W'(din)) ^ (base[W-1] ? POLY : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      pad_q  <= '0;
      open_q <= 1'b0;
      chk_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rem_q  <= (take || padding) ? stepped : base;
      if (start) begin
        open_q <= 1'b1;
        chk_q  <= mode;
        pad_q  <= '0;
      end else if (padding) begin
        pad_q <= pad_q - 1'b1;
        if (pad_q == CW'(1)) done_q <= 1'b1;
      end
      if (take && last) begin
        open_q <= 1'b0;
        if (chk_now) done_q <= 1'b1;
        else         pad_q  <= CW'(W);
      end
    end
  end

  assign crc   = rem_q;
  assign done  = done_q;
  assign error = done_q && chk_q && (rem_q != '0);

  a_r10_error_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !bit_valid) |=> (crc == '0));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !take && !padding) |=> $stable(crc));

  a_r4_pad_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    (padding && pad_q == CW'(1)) |=> done);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

endmodule

// File: tb/sim_serial_crc_unit.sv
module sim_serial_crc_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, bit_in = 1'b0, bit_valid = 1'b0, last = 1'b0;
  logic [15:0] crc;
  logic done, error;
  logic [1:0] crc2;
  logic done2, error2;

  int nchk = 0;
  int nerr = 0;
  int got_cnt;
  logic [15:0] got_crc;
  logic got_err;

  always #10 clk = ~clk;

  serial_crc_unit #(.W(16), .POLY(16'h1021)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .bit_in(bit_in),
    .bit_valid(bit_valid), .last(last), .crc(crc), .done(done), .error(error));

  serial_crc_unit #(.W(2), .POLY(2'b01)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .bit_in(bit_in),
    .bit_valid(bit_valid), .last(last), .crc(crc2), .done(done2), .error(error2));

  localparam int NV = 7;
  localparam logic [31:0] VMSG [NV] = '{32'h1, 32'hA5, 32'hFFFF, 32'h8000_0000,
                                        32'h1234_5678, 32'h5, 32'h0};
  localparam int VLEN [NV] = '{1, 8, 16, 32, 32, 3, 8};

  function automatic logic [15:0] ref_rem(input logic [127:0] v, input int len);
    logic [143:0] a;
    a = {16'h0, v} << 16;
    for (int i = len + 15; i >= 16; i--)
      if (a[i]) a = a ^ (144'h11021 << (i - 16));
    return a[15:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] v, input int len, input logic md,
                      input int gap, input logic noise, input logic flip);
    @(negedge clk);
    start = 1'b1; mode = md; bit_valid = 1'b0; last = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (flip) mode = ~md;
    for (int i = 0; i < len; i++) begin
      bit_in = v[len-1-i]; bit_valid = 1'b1; last = (i == len - 1);
      @(negedge clk);
      if (gap > 0 && i < len - 1) begin
        bit_valid = 1'b0; last = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    bit_valid = noise; bit_in = 1'b1; last = 1'b0;
    got_cnt = 0;
    while (!done && got_cnt < 64) begin
      @(negedge clk);
      got_cnt++;
    end
    got_crc = crc; got_err = error;
    bit_valid = 1'b0; mode = md;
    @(negedge clk);
    chk("R5 done single pulse", done, 0);
    chk("R5 crc held", crc, got_crc);
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [127:0] cw;
    logic [15:0] r;
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    chk("R1 reset crc", crc, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset error", error, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      r = ref_rem({96'h0, VMSG[k]}, VLEN[k]);
      send({96'h0, VMSG[k]}, VLEN[k], 1'b0, 0, 1'b0, 1'b0);
      chk("R3 generate remainder", got_crc, r);
      chk("R4 generate done delay", got_cnt, 16);
      cw = ({96'h0, VMSG[k]} << 16) | r;
      send(cw, VLEN[k] + 16, 1'b1, 0, 1'b0, 1'b0);
      chk("R6 clean codeword error", got_err, 0);
      chk("R6 clean codeword syndrome", got_crc, 0);
      chk("R4 check done delay", got_cnt, 0);
    end

    send(128'h31_32_33_34_35_36_37_38_39, 72, 1'b0, 0, 1'b0, 1'b0);
    chk("R3 known 72-bit value", got_crc, 16'h31C3);

    r = ref_rem(128'h1234_5678, 32);
    cw = (128'h1234_5678 << 16) | r;
    send(cw ^ (128'h1 << 30), 48, 1'b1, 0, 1'b0, 1'b0);
    chk("R7 single flip flagged", got_err, 1);
    send(cw ^ (128'h8001 << 10), 48, 1'b1, 0, 1'b0, 1'b0);
    chk("R7 burst flagged", got_err, 1);
    chk("R10 error with done", done, 0);
    chk("R10 error low after done", error, 0);

    send(128'hA5, 8, 1'b0, 3, 1'b0, 1'b0);
    chk("R8 gaps keep result", got_crc, ref_rem(128'hA5, 8));
    prev = crc;
    bit_valid = 1'b1; bit_in = 1'b1; last = 1'b1;
    repeat (4) @(negedge clk);
    bit_valid = 1'b0; last = 1'b0;
    chk("R8 stray bits ignored", crc, prev);
    chk("R8 stray bits no done", done, 0);

    send(128'h1234_5678, 32, 1'b0, 0, 1'b1, 1'b0);
    chk("R9 bits during padding ignored", got_crc, ref_rem(128'h1234_5678, 32));
    chk("R9 padding timing", got_cnt, 16);

    send(128'hFFFF, 16, 1'b0, 0, 1'b0, 1'b1);
    chk("R11 mode change ignored crc", got_crc, ref_rem(128'hFFFF, 16));
    chk("R11 mode change ignored timing", got_cnt, 16);

    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 start clears", crc, 0);

    send(128'b0110, 4, 1'b0, 0, 1'b0, 1'b0);
    chk("R12 worked example check bits", crc2, 2'b11);
    send(128'b011011, 6, 1'b1, 0, 1'b0, 1'b0);
    chk("R12 worked codeword syndrome", crc2, 2'b00);
    chk("R12 worked codeword error", error2, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule